// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit keeps the event flags of a serial bus controller and turns them into requests. Pulses from the transfer engine set bits in a 16-bit status register. An enable mask selects which of those bits drive the single combined interrupt line. Two DMA request lines follow the receive-ready and transmit-ready flags, each only while its own enable in a small DMA configuration register is set.

A build-time revision value picks one of two ways to clear the flags. Below revision 0x34, software clears a flag by reading a vector port. That read reports the lowest pending enabled event and clears it as a side effect. From revision 0x34 upward there is no vector: software clears flags by writing ones to the status port, and a test-register write can force the low six flags high. The bus protocol and the address decoding sit outside this unit. Register accesses reach it as write strobes with data and as a read strobe on the vector port.

Top module: `irq_status_vector`

## Requirements
- R1: `irq_o` is registered. After every clock edge it is 1 exactly when the stored status AND the stored mask is nonzero.
- R2: `rx_dma_req_o` equals status bit 3 while DMA-config bit 15 is set, and is 0 otherwise. `tx_dma_req_o` equals status bit 4 while DMA-config bit 7 is set, and is 0 otherwise. Both are registered like `irq_o`.
- R3: With revision below 0x34, `vec_data_o` shows, in the same cycle, one plus the index of the lowest set bit of status AND mask, or 0 if none is set. A cycle with `vec_rd_i` high clears that status bit at the clock edge.
- R4: With revision 0x34 or above, `vec_data_o` is always 0 and `vec_rd_i` has no effect. A status write clears each stored bit among 0, 1, 2 and 5 whose written data bit is 1, and leaves all other bits. Below revision 0x34 a status write has no effect.
- R5: A mask write keeps written bits 0 to 4 below revision 0x34, and bits 0 to 5 otherwise. All other mask bits read as 0.
- R6: A DMA-config write keeps only bits 15 and 7. A written bit 15 clears mask bit 3, and a written bit 7 clears mask bit 4. If a mask write comes in the same cycle, the DMA clearing is applied after it.
- R7: With revision 0x34 or above, a test write with data bit 11 set forces status bits 0 to 5 to 1. Below revision 0x34 a test write has no effect.
- R8: `stat_rd_o` is the stored status, with bit 12 ORed with `bus_busy_i` in the same cycle.
- R9: An event set pulse on a bit wins over a vector clear or a status-write clear of that bit in the same cycle.
- R10: A synchronous `rst` clears status, mask, DMA config and all three request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_set_i | input | 16 | Per-bit status set pulses from the transfer engine |
| bus_busy_i | input | 1 | Bus busy flag merged into status read bit 12 |
| stat_wr_i | input | 1 | Status write strobe (write-one-to-clear, new revision) |
| stat_wdata_i | input | 16 | Status write data |
| mask_wr_i | input | 1 | Enable mask write strobe |
| mask_wdata_i | input | 16 | Enable mask write data |
| dma_wr_i | input | 1 | DMA configuration write strobe |
| dma_wdata_i | input | 16 | DMA configuration write data |
| test_wr_i | input | 1 | Test register write strobe |
| test_wdata_i | input | 16 | Test register write data (bit 11 forces flags) |
| vec_rd_i | input | 1 | Vector read strobe (old revision) |
| vec_data_o | output | 5 | Vector value: lowest pending enabled index plus one, or 0 |
| stat_rd_o | output | 16 | Status readback including bus busy |
| mask_o | output | 16 | Enable mask readback |
| dma_cfg_o | output | 16 | DMA configuration readback |
| irq_o | output | 1 | Combined interrupt request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |

## Verification
The bench runs one instance of each revision side by side on the same stimulus. It sweeps every 6-bit mask against a spread of 6-bit event patterns. For each pair it drains the old variant through repeated vector reads. This separates lowest-bit priority from masking and shows that each read removes exactly one flag. The same sweep writes all ones to the new variant's status port, which shows which bits write-one-to-clear can reach. Directed cases put DMA enables against the ready flags and send a mask write and a DMA write in one cycle. They also race set pulses against both kinds of clear, toggle bus busy, and apply the test force, which only the new variant may obey.

// File: rtl/irqsv_pkg.sv
package irqsv_pkg;
   // Revision at and above which status is write-one-to-clear
   localparam logic [7:0] NEW_REV      = 8'h34;
   // Fixed flag positions decoded by the transfer engine and software
   localparam int         ERR_NACK_BIT = 1;
   localparam int         RX_RDY_BIT   = 3;
   localparam int         TX_RDY_BIT   = 4;
   localparam int         BUSY_BIT     = 12;
   localparam int         RX_DMA_BIT   = 15;
   localparam int         TX_DMA_BIT   = 7;
   localparam int         FORCE_BIT    = 11;
   localparam logic [15:0] W1C_BITS    = 16'h0027;
   localparam logic [15:0] FORCE_BITS  = 16'h003f;
   localparam logic [15:0] DMA_KEEP    = 16'h8080;
   localparam logic [15:0] OLD_KEEP    = 16'h001f;
   localparam logic [15:0] NEW_KEEP    = 16'h003f;
endpackage

// File: rtl/irqsv_vec_enc.sv
module irqsv_vec_enc #(
   parameter int W  = 16,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  pend_i,
   output logic          any_o,
   output logic [W-1:0]  onehot_o,
   output logic [IW-1:0] idx_o
);
   logic [W:0] below;
   assign below[0] = 1'b0;

   for (genvar g = 0; g < W; g++) begin : g_chain
      assign below[g+1]  = below[g] | pend_i[g];
      assign onehot_o[g] = pend_i[g] & ~below[g];
   end

   assign any_o = below[W];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < W; i++) begin
         if (onehot_o[i]) idx_o = idx_o | IW'(i);
      end
   end
endmodule

// File: rtl/irqsv_status.sv
module irqsv_status #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   input  logic [W-1:0] frc_i,
   output logic [W-1:0] stat_d_o,
   output logic [W-1:0] stat_q_o
);
   // set pulses and forcing are ORed after the clear: set wins
   assign stat_d_o = (stat_q_o & ~clr_i) | set_i | frc_i;

   always_ff @(posedge clk) begin
      if (rst) stat_q_o <= '0;
      else     stat_q_o <= stat_d_o;
   end

   // R9: every pulsed bit is present after the edge, whatever the clear
   p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
      (set_i != '0) |=> ((stat_q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irqsv_cfg.sv
module irqsv_cfg #(
   parameter int          W         = 16,
   parameter logic [15:0] MASK_KEEP = 16'h003f,
   parameter logic [15:0] DMA_KEEP  = 16'h8080,
   parameter int          RX_EN     = 15,
   parameter int          TX_EN     = 7,
   parameter int          RX_IE     = 3,
   parameter int          TX_IE     = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         mask_wr_i,
   input  logic [W-1:0] mask_wdata_i,
   input  logic         dma_wr_i,
   input  logic [W-1:0] dma_wdata_i,
   output logic [W-1:0] mask_d_o,
   output logic [W-1:0] mask_q_o,
   output logic [W-1:0] dma_d_o,
   output logic [W-1:0] dma_q_o
);
   localparam logic [W-1:0] MKEEP = W'(MASK_KEEP);
   localparam logic [W-1:0] DKEEP = W'(DMA_KEEP);

   always_comb begin
      mask_d_o = mask_wr_i ? (mask_wdata_i & MKEEP) : mask_q_o;
      dma_d_o  = dma_q_o;
      if (dma_wr_i) begin
         dma_d_o = dma_wdata_i & DKEEP;
         if (dma_wdata_i[RX_EN]) mask_d_o[RX_IE] = 1'b0;
         if (dma_wdata_i[TX_EN]) mask_d_o[TX_IE] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q_o <= '0;
         dma_q_o  <= '0;
      end else begin
         mask_q_o <= mask_d_o;
         dma_q_o  <= dma_d_o;
      end
   end

   // R6: a DMA enable for a direction turns its ready interrupt off
   p_dma_kills_rx_ie_r6: assert property (@(posedge clk) disable iff (rst)
      (dma_wr_i && dma_wdata_i[RX_EN]) |=> !mask_q_o[RX_IE]);
   p_dma_kills_tx_ie_r6: assert property (@(posedge clk) disable iff (rst)
      (dma_wr_i && dma_wdata_i[TX_EN]) |=> !mask_q_o[TX_IE]);
   // R5: a mask write never lands outside the kept field
   p_mask_field_r5: assert property (@(posedge clk) disable iff (rst)
      mask_wr_i |=> ((mask_q_o & ~MKEEP) == '0));
endmodule

// File: rtl/irq_status_vector.sv
module irq_status_vector #(
   parameter int         STAT_W   = 16,
   parameter logic [7:0] REVISION = 8'h34,
   localparam int        VEC_W    = $clog2(STAT_W + 1),
   localparam int        IDX_W    = $clog2(STAT_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [STAT_W-1:0] evt_set_i,
   input  logic              bus_busy_i,
   input  logic              stat_wr_i,
   input  logic [STAT_W-1:0] stat_wdata_i,
   input  logic              mask_wr_i,
   input  logic [STAT_W-1:0] mask_wdata_i,
   input  logic              dma_wr_i,
   input  logic [STAT_W-1:0] dma_wdata_i,
   input  logic              test_wr_i,
   input  logic [STAT_W-1:0] test_wdata_i,
   input  logic              vec_rd_i,
   output logic [VEC_W-1:0]  vec_data_o,
   output logic [STAT_W-1:0] stat_rd_o,
   output logic [STAT_W-1:0] mask_o,
   output logic [STAT_W-1:0] dma_cfg_o,
   output logic              irq_o,
   output logic              rx_dma_req_o,
   output logic              tx_dma_req_o
);
   import irqsv_pkg::*;

   localparam bit          IS_OLD = (REVISION < NEW_REV);
   localparam logic [15:0] KEEP   = IS_OLD ? OLD_KEEP : NEW_KEEP;

   if (STAT_W < 16) begin : g_bad_width
      $error("irq_status_vector: STAT_W must be at least 16");
   end

   logic [STAT_W-1:0] stat_q, stat_d, mask_q, mask_d, dma_q, dma_d;
   logic [STAT_W-1:0] clr_vec, frc_vec;

   irqsv_status #(.W(STAT_W)) u_status (
      .clk      (clk),
      .rst      (rst),
      .set_i    (evt_set_i),
      .clr_i    (clr_vec),
      .frc_i    (frc_vec),
      .stat_d_o (stat_d),
      .stat_q_o (stat_q)
   );

   irqsv_cfg #(
      .W         (STAT_W),
      .MASK_KEEP (KEEP),
      .DMA_KEEP  (DMA_KEEP),
      .RX_EN     (RX_DMA_BIT),
      .TX_EN     (TX_DMA_BIT),
      .RX_IE     (RX_RDY_BIT),
      .TX_IE     (TX_RDY_BIT)
   ) u_cfg (
      .clk          (clk),
      .rst          (rst),
      .mask_wr_i    (mask_wr_i),
      .mask_wdata_i (mask_wdata_i),
      .dma_wr_i     (dma_wr_i),
      .dma_wdata_i  (dma_wdata_i),
      .mask_d_o     (mask_d),
      .mask_q_o     (mask_q),
      .dma_d_o      (dma_d),
      .dma_q_o      (dma_q)
   );

   if (IS_OLD) begin : g_vector
      logic              vec_any;
      logic [STAT_W-1:0] vec_hot;
      logic [IDX_W-1:0]  vec_idx;

      irqsv_vec_enc #(.W(STAT_W)) u_enc (
         .pend_i   (stat_q & mask_q),
         .any_o    (vec_any),
         .onehot_o (vec_hot),
         .idx_o    (vec_idx)
      );

      assign vec_data_o = vec_any ? (VEC_W'(vec_idx) + VEC_W'(1)) : '0;
      assign clr_vec    = vec_rd_i ? vec_hot : '0;
      assign frc_vec    = '0;

      // R3: the reported flag is gone after the read unless re-pulsed
      p_vec_clears_r3: assert property (@(posedge clk) disable iff (rst)
         (vec_rd_i && vec_any && !evt_set_i[vec_idx]) |=> !stat_q[$past(vec_idx)]);
      // R4: status writes do nothing in this variant
      p_old_stat_wr_inert_r4: assert property (@(posedge clk) disable iff (rst)
         (stat_wr_i && !vec_rd_i && !test_wr_i && evt_set_i == '0) |=> $stable(stat_q));
   end else begin : g_direct
      assign vec_data_o = '0;
      assign clr_vec    = stat_wr_i ? (stat_wdata_i & STAT_W'(W1C_BITS)) : '0;
      assign frc_vec    = (test_wr_i && test_wdata_i[FORCE_BIT]) ? STAT_W'(FORCE_BITS) : '0;

      // R4: write-one-to-clear reaches the NACK flag
      p_w1c_nack_r4: assert property (@(posedge clk) disable iff (rst)
         (stat_wr_i && stat_wdata_i[ERR_NACK_BIT] && !evt_set_i[ERR_NACK_BIT] &&
          !(test_wr_i && test_wdata_i[FORCE_BIT])) |=> !stat_q[ERR_NACK_BIT]);
      // R7: forced flags are all present after the edge
      p_force_r7: assert property (@(posedge clk) disable iff (rst)
         (test_wr_i && test_wdata_i[FORCE_BIT]) |=> ((stat_q & STAT_W'(FORCE_BITS)) == STAT_W'(FORCE_BITS)));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_o        <= 1'b0;
         rx_dma_req_o <= 1'b0;
         tx_dma_req_o <= 1'b0;
      end else begin
         irq_o        <= |(stat_d & mask_d);
         rx_dma_req_o <= dma_d[RX_DMA_BIT] & stat_d[RX_RDY_BIT];
         tx_dma_req_o <= dma_d[TX_DMA_BIT] & stat_d[TX_RDY_BIT];
      end
   end

   assign stat_rd_o = stat_q | (STAT_W'(bus_busy_i) << BUSY_BIT);
   assign mask_o    = mask_q;
   assign dma_cfg_o = dma_q;

   // R1: the registered line agrees with the stored state
   p_irq_tracks_r1: assert property (@(posedge clk) disable iff (rst)
      irq_o == |(stat_q & mask_q));
   // R2: no DMA request without its enable
   p_rx_gate_r2: assert property (@(posedge clk) disable iff (rst)
      !dma_q[RX_DMA_BIT] |-> !rx_dma_req_o);
   p_tx_gate_r2: assert property (@(posedge clk) disable iff (rst)
      !dma_q[TX_DMA_BIT] |-> !tx_dma_req_o);
   // R10: reset leaves every output request low
   p_reset_quiet_r10: assert property (@(posedge clk)
      rst |=> (!irq_o && !rx_dma_req_o && !tx_dma_req_o));
endmodule

// File: tb/irq_status_vector_tb.sv
module irq_status_vector_tb_top;
   localparam int         CLK_P   = 10;
   localparam logic [7:0] REV_OLD = 8'h20;
   localparam logic [7:0] REV_NEW = 8'h34;

   logic clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic        rst, bus_busy, stat_wr, mask_wr, dma_wr, test_wr, vec_rd;
   logic [15:0] evt, stat_wd, mask_wd, dma_wd, test_wd;

   logic [4:0]  vec_w  [2];
   logic [15:0] stat_w [2];
   logic [15:0] mask_w [2];
   logic [15:0] dma_w  [2];
   logic        irq_w  [2];
   logic        rxr_w  [2];
   logic        txr_w  [2];

   for (genvar g = 0; g < 2; g++) begin : g_dut
      irq_status_vector #(.STAT_W(16), .REVISION(g == 0 ? REV_OLD : REV_NEW)) dut_i (
         .clk(clk), .rst(rst), .evt_set_i(evt), .bus_busy_i(bus_busy),
         .stat_wr_i(stat_wr), .stat_wdata_i(stat_wd),
         .mask_wr_i(mask_wr), .mask_wdata_i(mask_wd),
         .dma_wr_i(dma_wr), .dma_wdata_i(dma_wd),
         .test_wr_i(test_wr), .test_wdata_i(test_wd),
         .vec_rd_i(vec_rd), .vec_data_o(vec_w[g]), .stat_rd_o(stat_w[g]),
         .mask_o(mask_w[g]), .dma_cfg_o(dma_w[g]), .irq_o(irq_w[g]),
         .rx_dma_req_o(rxr_w[g]), .tx_dma_req_o(txr_w[g]));
   end

   int checks = 0;
   int fails  = 0;
   logic [15:0] ms [2];
   logic [15:0] mm [2];
   logic [15:0] md [2];

   task automatic chk(input string tag, input int dut, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s dut%0d actual=%h expected=%h", tag, dut, act, exp);
      end
   endtask

   function automatic logic [4:0] low_vec(input logic [15:0] p);
      for (int i = 0; i < 16; i++) if (p[i]) return 5'(i + 1);
      return 5'd0;
   endfunction

   task automatic idle();
      evt = '0; stat_wr = 0; mask_wr = 0; dma_wr = 0; test_wr = 0; vec_rd = 0;
      stat_wd = '0; mask_wd = '0; dma_wd = '0; test_wd = '0;
   endtask

   // one clock edge; the model follows the requirements
   task automatic step();
      @(posedge clk);
      for (int k = 0; k < 2; k++) begin
         logic [15:0] pend, clr, frc, nm;
         pend = ms[k] & mm[k];
         clr = '0; frc = '0;
         if (k == 0) begin
            if (vec_rd) clr = pend & (~pend + 16'd1);
         end else begin
            if (stat_wr) clr = stat_wd & 16'h0027;
            if (test_wr && test_wd[11]) frc = 16'h003f;
         end
         nm = mask_wr ? (mask_wd & (k == 0 ? 16'h001f : 16'h003f)) : mm[k];
         if (dma_wr) begin
            if (dma_wd[15]) nm[3] = 1'b0;
            if (dma_wd[7])  nm[4] = 1'b0;
            md[k] = dma_wd & 16'h8080;
         end
         ms[k] = (ms[k] & ~clr) | evt | frc;
         mm[k] = nm;
         if (rst) begin ms[k] = '0; mm[k] = '0; md[k] = '0; end
      end
      @(negedge clk);
      idle();
   endtask

   task automatic check_all(input string tag);
      for (int k = 0; k < 2; k++) begin
         chk({tag, " R8 status"}, k, stat_w[k], ms[k] | (16'(bus_busy) << 12));
         chk({tag, " mask"},      k, mask_w[k], mm[k]);
         chk({tag, " dmacfg"},    k, dma_w[k],  md[k]);
         chk({tag, " R1 irq"},    k, 16'(irq_w[k]), 16'(|(ms[k] & mm[k])));
         chk({tag, " R2 rxreq"},  k, 16'(rxr_w[k]), 16'(md[k][15] & ms[k][3]));
         chk({tag, " R2 txreq"},  k, 16'(txr_w[k]), 16'(md[k][7] & ms[k][4]));
      end
   endtask

   task automatic do_reset();
      rst = 1; step(); rst = 0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(CLK_P * 150000);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      idle(); bus_busy = 0; rst = 1;
      for (int k = 0; k < 2; k++) begin ms[k] = 'x; mm[k] = 'x; md[k] = 'x; end
      @(negedge clk);
      do_reset();
      check_all("R10 reset");

      // R3/R4/R1 sweep: every 6-bit mask against spread event patterns
      for (int m = 0; m < 64; m++) begin
         for (int p = 1; p < 64; p += 5) begin
            do_reset();
            mask_wr = 1; mask_wd = 16'(m); step();
            evt = 16'(p); step();
            check_all("R1 sweep");
            for (int r = 0; r < 7; r++) begin
               vec_rd = 1; #1;
               chk("R3 vector", 0, 16'(vec_w[0]), 16'(low_vec(ms[0] & mm[0])));
               chk("R4 no vector", 1, 16'(vec_w[1]), 16'd0);
               step();
               check_all("R3 drain");
            end
            stat_wr = 1; stat_wd = 16'hffff; step();
            check_all("R4 w1c");
         end
      end

      // R5: wide mask write keeps only the revision's field
      do_reset();
      mask_wr = 1; mask_wd = 16'hffff; step();
      check_all("R5 mask keep");

      // R6 and R2: DMA enables against the ready flags
      for (int d = 0; d < 4; d++) begin
         do_reset();
         mask_wr = 1; mask_wd = 16'h003f; step();
         evt = (d[0] ? 16'h0008 : 16'h0) | (d[1] ? 16'h0010 : 16'h0); step();
         dma_wr = 1; dma_wd = 16'hffff ^ (d[0] ? 16'h0 : 16'h8000); step();
         check_all("R6 R2 dma");
         dma_wr = 1; dma_wd = 16'h8080; mask_wr = 1; mask_wd = 16'h003f; step();
         check_all("R6 same cycle");
      end

      // R7: test force only in the new variant
      do_reset();
      test_wr = 1; test_wd = 16'h0800; step();
      check_all("R7 force");
      test_wr = 1; test_wd = 16'hf7ff; step();
      check_all("R7 no force bit");

      // R8: bus busy in read bit 12
      bus_busy = 1; #1;
      check_all("R8 busy");
      evt = 16'h1000; step();
      bus_busy = 0; #1;
      check_all("R8 stored bit12");

      // R9: set beats clear in the same cycle
      do_reset();
      mask_wr = 1; mask_wd = 16'h003f; step();
      evt = 16'h0003; step();
      vec_rd = 1; evt = 16'h0001; stat_wr = 1; stat_wd = 16'h0027; step();
      check_all("R9 set wins");
      chk("R9 bit0 kept", 0, 16'(stat_w[0][0]), 16'd1);
      chk("R9 bit0 kept", 1, 16'(stat_w[1][0]), 16'd1);

      // R4: status write ignored below the revision threshold
      stat_wr = 1; stat_wd = 16'hffff; step();
      check_all("R4 old ignore");

      // R1: high unmasked flags leave irq low
      do_reset();
      evt = 16'h8400; step();
      check_all("R1 unmasked");

      summary();
      $finish;
   end
endmodule